// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, and moves data across them in either direction. Each direction has its own storage register. A driven bus can carry either the live value of the opposite bus or the value held in that direction's register. The bus width is split into independent lanes. Each lane has its own output enable, direction, pair of capture strobes and pair of source selects. Tying the control inputs of all lanes together makes the block act as one full-width transceiver.

The buses are not modelled as tri-state pads. Each side is a set of signals: an incoming value, an indication that some external agent is driving it, an outgoing value and a drive enable. When no external agent drives a bus, that bus keeps its last driven value. The storage registers keep working while both outputs are isolated. Every output, including the drive enables, is registered. A change of source select therefore appears one clock later as a single clean step.

Top module: `regbus_xcvr`

## Requirements
- R1: While reset is asserted and after it is released, both drive enables of every lane are 0 and both storage registers hold 0. A lane that selects stored data right after reset drives 0.
- R2: The A-to-B register of a lane loads the A bus value only on a 0-to-1 transition of that lane's `cap_ab` strobe, as sampled by `clk`. If the strobe is held at 1, no further load happens.
- R3: The B-to-A register of a lane loads the B bus value only on a 0-to-1 transition of that lane's `cap_ba` strobe, as sampled by `clk`. If the strobe is held at 1, no further load happens.
- R4: With `oe_n`=0, `dir`=1 drives B (`b_oe_o`=1) and leaves A undriven. `dir`=0 drives A and leaves B undriven. The enables follow one clock after the control is sampled.
- R5: With `oe_n`=1, neither bus of the lane is driven. Both registers still capture on their strobes, and the captured data can be driven out later.
- R6: A select of 0 (live) makes the driven bus carry the opposite bus value that was sampled on the previous clock.
- R7: A select of 1 (stored) makes the driven bus carry that direction's register contents as they were before the same clock edge. Later changes on the opposite bus do not affect it.
- R8: Toggling a select moves the driven value from one source to the other in exactly one clock, with no other value in between.
- R9: In any lane, the A and B drive enables are never 1 at the same time.
- R10: Lanes are independent. The controls of one lane do not affect the enables, data or registers of another lane.
- R11: When a bus's drive indication (`a_drv_i`/`b_drv_i`) is 0, the block uses the last value it saw while that indication was 1. This applies to both the live path and capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| oe_n | input | LANES | Active-low output enable per lane |
| dir | input | LANES | Per lane: 1 drives B from A, 0 drives A from B |
| cap_ab | input | LANES | Capture strobe for the A-to-B register |
| cap_ba | input | LANES | Capture strobe for the B-to-A register |
| sel_ab | input | LANES | B output source: 0 live A, 1 stored |
| sel_ba | input | LANES | A output source: 0 live B, 1 stored |
| a_i | input | LANES*LANE_W | Incoming A bus value |
| a_drv_i | input | LANES | A lane is driven by an external agent |
| b_i | input | LANES*LANE_W | Incoming B bus value |
| b_drv_i | input | LANES | B lane is driven by an external agent |
| a_o | output | LANES*LANE_W | Value driven onto A |
| a_oe_o | output | LANES | Drive enable for A |
| b_o | output | LANES*LANE_W | Value driven onto B |
| b_oe_o | output | LANES | Drive enable for B |

## Verification
The bench builds the block with its defaults, two lanes of eight bits. With two lanes it can give the lanes opposite directions and make a capture strobe pulse in one lane only, and it can also drive all lanes alike as a single sixteen-bit transfer. Eight-bit lanes leave room for distinct patterns per lane, so a value that leaks between lanes or between the live and stored sources shows up as a visible miscompare.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (drv_i) held_d = bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign bus_o = drv_i ? bus_i : held_q;

  AST_FLOAT_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_i ##1 !drv_i) |-> (bus_o == $past(bus_i))) else $error("floating bus lost value"); // R11
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  logic         prev_q;
  logic         rise;
  logic [W-1:0] store_q, store_d;

  always_comb begin
    rise    = strobe_i && !prev_q;
    store_d = store_q;
    if (rise) store_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      store_q <= '0;
    end else begin
      prev_q  <= strobe_i;
      store_q <= store_d;
    end
  end

  assign data_o = store_q;

  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !prev_q) |=> (data_o == $past(data_i))) else $error("capture missed"); // R2 R3
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_i && !prev_q) |=> $stable(data_o)) else $error("register changed without edge"); // R2 R3
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              dir,
  input  logic              cap_ab,
  input  logic              cap_ba,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic [LANE_W-1:0] a_i,
  input  logic              a_drv_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              b_drv_i,
  output logic [LANE_W-1:0] a_o,
  output logic              a_oe_o,
  output logic [LANE_W-1:0] b_o,
  output logic              b_oe_o
);
  logic [LANE_W-1:0] a_eff, b_eff, st_ab, st_ba;
  logic [LANE_W-1:0] a_o_q, a_o_d, b_o_q, b_o_d;
  logic              a_oe_q, a_oe_d, b_oe_q, b_oe_d;
  xfer_dir_e         dir_e;
  src_sel_e          src_ab, src_ba;

  xcvr_bus_hold #(.W(LANE_W)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .drv_i(a_drv_i), .bus_i(a_i), .bus_o(a_eff));
  xcvr_bus_hold #(.W(LANE_W)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .drv_i(b_drv_i), .bus_i(b_i), .bus_o(b_eff));

  xcvr_store_reg #(.W(LANE_W)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .strobe_i(cap_ab), .data_i(a_eff), .data_o(st_ab));
  xcvr_store_reg #(.W(LANE_W)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .strobe_i(cap_ba), .data_i(b_eff), .data_o(st_ba));

  always_comb begin
    dir_e  = xfer_dir_e'(dir);
    src_ab = src_sel_e'(sel_ab);
    src_ba = src_sel_e'(sel_ba);
    b_oe_d = !oe_n && (dir_e == DIR_TO_B);
    a_oe_d = !oe_n && (dir_e == DIR_TO_A);
    b_o_d  = b_o_q;
    a_o_d  = a_o_q;
    if (b_oe_d) b_o_d = (src_ab == SRC_STORED) ? st_ab : a_eff;
    if (a_oe_d) a_o_d = (src_ba == SRC_STORED) ? st_ba : b_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_oe_q <= 1'b0;
      b_oe_q <= 1'b0;
      a_o_q  <= '0;
      b_o_q  <= '0;
    end else begin
      a_oe_q <= a_oe_d;
      b_oe_q <= b_oe_d;
      a_o_q  <= a_o_d;
      b_o_q  <= b_o_d;
    end
  end

  assign a_o    = a_o_q;
  assign b_o    = b_o_q;
  assign a_oe_o = a_oe_q;
  assign b_oe_o = b_oe_q;

  AST_ONE_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe_q && b_oe_q)) else $error("both buses driven"); // R9
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (!a_oe_q && !b_oe_q)) else $error("drive while isolated"); // R5
  AST_DIR_DRIVES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir) |=> (b_oe_q && !a_oe_q)) else $error("direction B wrong"); // R4
  AST_DIR_DRIVES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir) |=> (a_oe_q && !b_oe_q)) else $error("direction A wrong"); // R4
  AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir && !sel_ab) |=> (b_o_q == $past(a_eff))) else $error("live path wrong"); // R6
  AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir && sel_ab) |=> (b_o_q == $past(st_ab))) else $error("stored path wrong"); // R7
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        oe_n,
  input  logic [LANES-1:0]        dir,
  input  logic [LANES-1:0]        cap_ab,
  input  logic [LANES-1:0]        cap_ba,
  input  logic [LANES-1:0]        sel_ab,
  input  logic [LANES-1:0]        sel_ba,
  input  logic [LANES*LANE_W-1:0] a_i,
  input  logic [LANES-1:0]        a_drv_i,
  input  logic [LANES*LANE_W-1:0] b_i,
  input  logic [LANES-1:0]        b_drv_i,
  output logic [LANES*LANE_W-1:0] a_o,
  output logic [LANES-1:0]        a_oe_o,
  output logic [LANES*LANE_W-1:0] b_o,
  output logic [LANES-1:0]        b_oe_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .oe_n    (oe_n[l]),
      .dir     (dir[l]),
      .cap_ab  (cap_ab[l]),
      .cap_ba  (cap_ba[l]),
      .sel_ab  (sel_ab[l]),
      .sel_ba  (sel_ba[l]),
      .a_i     (a_i[l*LANE_W +: LANE_W]),
      .a_drv_i (a_drv_i[l]),
      .b_i     (b_i[l*LANE_W +: LANE_W]),
      .b_drv_i (b_drv_i[l]),
      .a_o     (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o  (a_oe_o[l]),
      .b_o     (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o  (b_oe_o[l])
    );
  end
endmodule

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
  localparam int L  = 2;
  localparam int LW = 8;
  localparam int W  = L * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [L-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba, a_drv_i, b_drv_i;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] a_o, b_o;
  logic [L-1:0] a_oe_o, b_oe_o;

  regbus_xcvr #(.LANES(L), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_i(a_i), .a_drv_i(a_drv_i), .b_i(b_i),
    .b_drv_i(b_drv_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o));

  typedef struct {
    logic [L-1:0] a_oe;
    logic [L-1:0] b_oe;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;
    string        tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_bad = 0;

  logic [LW-1:0] m_hold_a [L];
  logic [LW-1:0] m_hold_b [L];
  logic [LW-1:0] m_st_ab  [L];
  logic [LW-1:0] m_st_ba  [L];
  logic          m_pa     [L];
  logic          m_pb     [L];

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < L; l++) begin
      m_hold_a[l] = '0; m_hold_b[l] = '0;
      m_st_ab[l]  = '0; m_st_ba[l]  = '0;
      m_pa[l]     = 1'b0; m_pb[l]   = 1'b0;
    end
  endtask

  // Driver: predicts the outputs after the coming edge, pushes them, then waits.
  task automatic step(input string tag);
    exp_t e;
    logic [LW-1:0] ea, eb;
    e.tag = tag;
    e.a_val = '0;
    e.b_val = '0;
    for (int l = 0; l < L; l++) begin
      ea = a_drv_i[l] ? a_i[l*LW +: LW] : m_hold_a[l];
      eb = b_drv_i[l] ? b_i[l*LW +: LW] : m_hold_b[l];
      e.b_oe[l] = !oe_n[l] && dir[l];
      e.a_oe[l] = !oe_n[l] && !dir[l];
      e.b_val[l*LW +: LW] = sel_ab[l] ? m_st_ab[l] : ea;
      e.a_val[l*LW +: LW] = sel_ba[l] ? m_st_ba[l] : eb;
      m_hold_a[l] = ea;
      m_hold_b[l] = eb;
      if (cap_ab[l] && !m_pa[l]) m_st_ab[l] = ea;
      if (cap_ba[l] && !m_pb[l]) m_st_ba[l] = eb;
      m_pa[l] = cap_ab[l];
      m_pb[l] = cap_ba[l];
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: pops one prediction per edge and compares the driven lanes.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      logic [W-1:0] am, bm;
      mon_e = sb.pop_front();
      am = '0;
      bm = '0;
      for (int l = 0; l < L; l++) begin
        if (mon_e.a_oe[l]) am[l*LW +: LW] = '1;
        if (mon_e.b_oe[l]) bm[l*LW +: LW] = '1;
      end
      chk({mon_e.tag, " enables"}, W'({a_oe_o, b_oe_o}), W'({mon_e.a_oe, mon_e.b_oe}));
      chk({mon_e.tag, " A data"}, a_o & am, mon_e.a_val & am);
      chk({mon_e.tag, " B data"}, b_o & bm, mon_e.b_val & bm);
      chk("R9 single driver", W'(a_oe_o & b_oe_o), '0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    a_i = '0; b_i = '0; a_drv_i = '1; b_drv_i = '1;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset A enable", W'(a_oe_o), '0);
    chk("R1 reset B enable", W'(b_oe_o), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: stored data after reset is zero
    oe_n = '0; dir = '1; sel_ab = '1; a_i = 16'hA5C3;
    step("R1 stored cleared");
    dir = '0; sel_ba = '1; b_i = 16'h3C5A;
    step("R1 stored cleared BA");

    // R6 / R4: live paths both directions
    dir = '1; sel_ab = '0;
    foreach (a_i[k]) if (k < 4) begin
      a_i = 16'h1111 * (k + 1) ^ 16'h00F0;
      step("R6 live A to B");
    end
    dir = '0; sel_ba = '0;
    b_i = 16'h8421; step("R4 drive A");
    b_i = 16'h7E81; step("R6 live B to A");
    dir = 2'b01; a_i = 16'hC0DE; b_i = 16'hBEEF;
    step("R4 R10 split directions");

    // R2 / R7: capture A, then hold strobe high
    dir = '1; sel_ab = '1; a_i = 16'h1234; cap_ab = '1;
    step("R2 capture rise");
    a_i = 16'hFFFF;
    step("R2 strobe held high");
    cap_ab = '0; a_i = 16'h0000;
    step("R7 stored output");
    a_i = 16'h5555;
    step("R7 stored ignores A");

    // R3: capture B
    dir = '0; sel_ba = '1; b_i = 16'h9876; cap_ba = '1;
    step("R3 capture rise");
    b_i = 16'h0101;
    step("R3 strobe held high");
    cap_ba = '0; b_i = 16'hAAAA;
    step("R3 stored output");

    // R5: isolation with capture in both registers
    oe_n = '1; a_i = 16'h0F0F; b_i = 16'hF0F0; cap_ab = '1; cap_ba = '1;
    step("R5 isolated capture");
    cap_ab = '0; cap_ba = '0; a_i = 16'h2222; b_i = 16'h3333;
    step("R5 isolated idle");
    oe_n = '0; dir = '1; sel_ab = '1;
    step("R5 stored A after isolation");
    dir = '0; sel_ba = '1;
    step("R5 stored B after isolation");

    // R8: toggle the select every cycle
    dir = '1; sel_ab = '0;
    for (int k = 0; k < 6; k++) begin
      sel_ab = ~sel_ab;
      a_i = 16'h4000 + 16'(k * 16'h0313);
      step("R8 select toggle");
    end

    // R10: lanes with different controls, one-lane capture
    oe_n = 2'b10; dir = 2'b01; sel_ab = 2'b00; sel_ba = 2'b00;
    a_i = 16'h6C39; b_i = 16'h93C6; cap_ab = 2'b01;
    step("R10 lane0 only");
    cap_ab = '0; oe_n = '0; dir = '1; sel_ab = '1; a_i = 16'h0000;
    step("R10 lane capture isolated");

    // R11: floating A bus keeps last value
    sel_ab = '0; a_i = 16'h5A5A; a_drv_i = '1;
    step("R11 driven");
    a_drv_i = '0; a_i = 16'hDEAD;
    step("R11 floating live");
    cap_ab = '1;
    step("R11 floating capture");
    cap_ab = '0; sel_ab = '1; a_i = 16'hBEEF;
    step("R11 stored from floating");
    a_drv_i = '1;
    step("R11 driven again");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule